// File: doc/BRIEF.md
# Character display instruction decoder

This block is the command and data front end of a character display controller. A host drives a register-select bit, a read/write bit, an 8-bit data byte and a one-cycle strobe. With register-select low the byte is an instruction. The block decodes four instructions: a configuration load (bus width, line count, brightness code), an address load that points the address counter into the character-generator RAM, an address load that points it into the display-data RAM, and a read of the address counter. With register-select high the access is a data byte. It is written to, or read from, whichever RAM the most recent address load selected, and the address counter then steps forward.

The block never reports busy. The busy bit it returns is always zero, and it accepts a new access on every clock in which the strobe is high, with no execution delay. Both RAMs are internal arrays with synchronous read. They are written so that block RAM can be inferred. Read data appears one clock after the read strobe, marked by a one-cycle valid pulse. Instruction codes that the block does not decode are dropped and leave all state as it was.

Top module: `chardisp_cmd_decoder`

## Requirements
- R1: After a synchronous reset, bus_wide_o=1, two_lines_o=1 and bright_code_o=00, the address counter reads 0, and data accesses go to the display-data RAM.
- R2: A strobe with rs=0, rw=0 and byte[7:5]=001 is a configuration load. byte[4] sets bus_wide_o (1 = 8-bit bus, 0 = 4-bit bus), byte[3] sets two_lines_o (1 = two lines), and byte[1:0] sets bright_code_o (00=100%, 01=75%, 10=50%, 11=25%). byte[2] has no effect.
- R3: A configuration load leaves the address counter, the RAM selection and both RAM contents unchanged.
- R4: A strobe with rs=0, rw=0 and byte[7:6]=01 loads byte[5:0] into the address counter and selects the character-generator RAM.
- R5: A strobe with rs=0, rw=0 and byte[7]=1 loads byte[6:0] into the address counter and selects the display-data RAM.
- R6: A strobe with rs=0, rw=1 returns, one clock later, rd_data_o = {1'b0, address counter}. Bit 7 is the busy flag and is always 0. The address counter is left unchanged.
- R7: A strobe with rs=1, rw=0 stores the byte at the address counter in the selected RAM and then increments the counter. It does not raise rd_valid_o.
- R8: A strobe with rs=1, rw=1 returns, one clock later, the byte at the address counter in the selected RAM, with rd_valid_o high for one clock, and then increments the counter.
- R9: When the character-generator RAM is selected the counter wraps within 6 bits (63 to 0). When the display-data RAM is selected it wraps within 7 bits (127 to 0).
- R10: Accesses are accepted on consecutive clocks with no stall, and each one takes effect at the clock edge where its strobe is high.
- R11: A strobe with rs=0, rw=0 and byte[7:5]=000 changes no configuration output, no address counter, no RAM selection and no RAM content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb_i | input | 1 | Access strobe, one access per high cycle |
| host_rs_i | input | 1 | Register select: 0 instruction, 1 data |
| host_rw_i | input | 1 | Direction: 0 write, 1 read |
| host_d_i | input | 8 | Instruction or data byte from the host |
| rd_data_o | output | 8 | Read result: RAM byte, or busy flag plus counter |
| rd_valid_o | output | 1 | High for one clock when rd_data_o holds a read result |
| bus_wide_o | output | 1 | Bus width: 1 = 8-bit, 0 = 4-bit |
| two_lines_o | output | 1 | Line count: 1 = two lines, 0 = one line |
| bright_code_o | output | 2 | Brightness code: 00 full down to 11 quarter |

## Verification
On every cycle the assertions check these properties. The busy bit and the counter come back correctly one clock after a counter read. Configuration only changes on a configuration load. A configuration load leaves the counter and the RAM selection alone. A data access steps the counter by exactly one, modulo the width of the selected RAM. The upper counter bit stays clear while the character-generator RAM is selected, and a valid pulse follows every read and nothing else. Only the bench scenarios can show that bytes land in the right RAM and come back unchanged. They also show that the two RAMs do not alias, that the counter wraps at 63 and 127, that undecoded codes and the don't-care bit change nothing, and that reset restores the display-data selection.

// File: rtl/cdd_pkg.sv
package cdd_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CFG,
    OP_CGSET,
    OP_DDSET,
    OP_ACRD,
    OP_WRITE,
    OP_READ
  } op_e;

  typedef enum logic {
    SEL_DD = 1'b0,
    SEL_CG = 1'b1
  } ramsel_e;

  typedef struct packed {
    logic       wide;
    logic       two;
    logic [1:0] bright;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{wide: 1'b1, two: 1'b1, bright: 2'b00};

endpackage

// File: rtl/cdd_op_decode.sv
module cdd_op_decode
  import cdd_pkg::*;
(
  input  logic       stb,
  input  logic       rs,
  input  logic       rw,
  input  logic [2:0] hi,
  output op_e        op
);

  always_comb begin
    op = OP_NONE;
    if (stb) begin
      unique case ({rs, rw})
        2'b00: begin
          if (hi[2])      op = OP_DDSET;
          else if (hi[1]) op = OP_CGSET;
          else if (hi[0]) op = OP_CFG;
          else            op = OP_NONE;
        end
        2'b01:   op = OP_ACRD;
        2'b10:   op = OP_WRITE;
        default: op = OP_READ;
      endcase
    end
  end

endmodule

// File: rtl/cdd_ctrl_regs.sv
module cdd_ctrl_regs
  import cdd_pkg::*;
#(
  parameter int CG_AW = 6,
  parameter int DD_AW = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [7:0]       din,
  output cfg_t             cfg,
  output logic [DD_AW-1:0] ac,
  output ramsel_e          sel
);

  localparam int AC_W = DD_AW;
  localparam int PAD  = AC_W - CG_AW;

  logic [CG_AW-1:0] cg_inc;
  logic [AC_W-1:0]  ac_inc;
  logic             unused_bits;

  assign cg_inc      = ac[CG_AW-1:0] + 1'b1;
  assign ac_inc      = (sel == SEL_CG) ? {{PAD{1'b0}}, cg_inc} : ac + 1'b1;
  assign unused_bits = ^{din[7], din[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      ac  <= '0;
      sel <= SEL_DD;
    end else begin
      case (op)
        OP_CFG: begin
          cfg.wide   <= din[4];
          cfg.two    <= din[3];
          cfg.bright <= din[1:0];
        end
        OP_CGSET: begin
          ac  <= {{PAD{1'b0}}, din[CG_AW-1:0]};
          sel <= SEL_CG;
        end
        OP_DDSET: begin
          ac  <= din[AC_W-1:0];
          sel <= SEL_DD;
        end
        OP_WRITE, OP_READ: ac <= ac_inc;
        default: ;
      endcase
    end
  end

  // R3: a configuration load keeps the counter and the RAM selection
  a_r3_cfg_keeps_ac: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_CFG)) |-> (ac == $past(ac) && sel == $past(sel)));

  // R11: configuration changes only through a configuration load
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op != OP_CFG)) |-> (cfg == $past(cfg)));

  // R7 / R8 / R9: a data access steps the counter by one within the selected width
  a_r9_dd_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_WRITE || op == OP_READ) && $past(sel) == SEL_DD)
      |-> (ac == $past(ac) + AC_W'(1)));

  a_r9_cg_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_WRITE || op == OP_READ) && $past(sel) == SEL_CG)
      |-> (ac[CG_AW-1:0] == $past(ac[CG_AW-1:0]) + CG_AW'(1)));

  // R4: the counter never leaves the 6-bit range while the character RAM is selected
  a_r4_cg_range: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_CG) |-> (ac[AC_W-1:CG_AW] == '0));

endmodule

// File: rtl/cdd_ram.sv
module cdd_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/chardisp_cmd_decoder.sv
module chardisp_cmd_decoder
  import cdd_pkg::*;
#(
  parameter int CG_AW = 6,
  parameter int DD_AW = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_stb_i,
  input  logic       host_rs_i,
  input  logic       host_rw_i,
  input  logic [7:0] host_d_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  output logic       bus_wide_o,
  output logic       two_lines_o,
  output logic [1:0] bright_code_o
);

  localparam int DW = 8;

  op_e              op;
  cfg_t             cfg;
  logic [DD_AW-1:0] ac;
  ramsel_e          sel;
  logic [DW-1:0]    cg_q;
  logic [DW-1:0]    dd_q;
  logic             cg_we, cg_re, dd_we, dd_re;
  logic             src_ac;
  logic             src_cg;
  logic [DD_AW-1:0] ac_snap;

  cdd_op_decode u_dec (
    .stb (host_stb_i),
    .rs  (host_rs_i),
    .rw  (host_rw_i),
    .hi  (host_d_i[7:5]),
    .op  (op)
  );

  cdd_ctrl_regs #(.CG_AW(CG_AW), .DD_AW(DD_AW)) u_regs (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .din (host_d_i),
    .cfg (cfg),
    .ac  (ac),
    .sel (sel)
  );

  assign cg_we = (op == OP_WRITE) && (sel == SEL_CG);
  assign cg_re = (op == OP_READ)  && (sel == SEL_CG);
  assign dd_we = (op == OP_WRITE) && (sel == SEL_DD);
  assign dd_re = (op == OP_READ)  && (sel == SEL_DD);

  cdd_ram #(.AW(CG_AW), .DW(DW)) u_cgram (
    .clk   (clk),
    .we    (cg_we),
    .re    (cg_re),
    .addr  (ac[CG_AW-1:0]),
    .wdata (host_d_i),
    .rdata (cg_q)
  );

  cdd_ram #(.AW(DD_AW), .DW(DW)) u_ddram (
    .clk   (clk),
    .we    (dd_we),
    .re    (dd_re),
    .addr  (ac),
    .wdata (host_d_i),
    .rdata (dd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      src_ac     <= 1'b0;
      src_cg     <= 1'b0;
      ac_snap    <= '0;
    end else begin
      rd_valid_o <= (op == OP_READ) || (op == OP_ACRD);
      src_ac     <= (op == OP_ACRD);
      src_cg     <= (sel == SEL_CG);
      ac_snap    <= ac;
    end
  end

  always_comb begin
    if (src_ac)      rd_data_o = {1'b0, DW'(ac_snap)} [DW-1:0];
    else if (src_cg) rd_data_o = cg_q;
    else             rd_data_o = dd_q;
  end

  assign bus_wide_o    = cfg.wide;
  assign two_lines_o   = cfg.two;
  assign bright_code_o = cfg.bright;

  // R6: a counter read returns busy=0 and the counter value one clock later
  a_r6_ac_read: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_ACRD))
      |-> (rd_valid_o && rd_data_o == {1'b0, $past(ac)}));

  // R8: a valid pulse follows every read and nothing else
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> (rd_valid_o == $past(op == OP_READ || op == OP_ACRD)));

  // R7: a write never produces read data
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op == OP_WRITE)) |-> !rd_valid_o);

endmodule

// File: tb/test_chardisp_cmd_decoder.sv
module test_chardisp_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst;
  logic       stb, rs, rw;
  logic [7:0] din;
  logic [7:0] rd_data;
  logic       rd_valid, wide, two;
  logic [1:0] bright;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  chardisp_cmd_decoder i_chardisp_cmd_decoder (
    .clk (clk), .rst (rst),
    .host_stb_i (stb), .host_rs_i (rs), .host_rw_i (rw), .host_d_i (din),
    .rd_data_o (rd_data), .rd_valid_o (rd_valid),
    .bus_wide_o (wide), .two_lines_o (two), .bright_code_o (bright)
  );

  // {rs, rw, byte, exp_valid, exp_data, exp_wide, exp_two, exp_bright}
  localparam int NV = 31;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b1,8'h00, 1'b1,8'h00, 1'b1,1'b1,2'b00}, // R1 counter 0 after reset
    {1'b0,1'b0,8'h26, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R2 cfg 4-bit, 1 line, 50%
    {1'b0,1'b1,8'h00, 1'b1,8'h00, 1'b0,1'b0,2'b10}, // R3 counter kept
    {1'b0,1'b0,8'h85, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R5 dd addr 5
    {1'b1,1'b0,8'h41, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R7 write
    {1'b1,1'b0,8'h42, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R10 back-to-back write
    {1'b0,1'b1,8'h00, 1'b1,8'h07, 1'b0,1'b0,2'b10}, // R7 counter 7
    {1'b0,1'b0,8'h0F, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R11 undecoded
    {1'b0,1'b1,8'h00, 1'b1,8'h07, 1'b0,1'b0,2'b10}, // R11 counter kept
    {1'b0,1'b0,8'h85, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R5
    {1'b1,1'b1,8'h00, 1'b1,8'h41, 1'b0,1'b0,2'b10}, // R8 read
    {1'b1,1'b1,8'h00, 1'b1,8'h42, 1'b0,1'b0,2'b10}, // R8 read next
    {1'b0,1'b0,8'h7F, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R4 cg addr 63
    {1'b1,1'b0,8'h99, 1'b0,8'h00, 1'b0,1'b0,2'b10}, // R7 cg write
    {1'b0,1'b1,8'h00, 1'b1,8'h00, 1'b0,1'b0,2'b10}, // R9 cg wrap to 0
    {1'b0,1'b0,8'h3B, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R2 cfg 8-bit, 2 lines, 25%
    {1'b0,1'b1,8'h00, 1'b1,8'h00, 1'b1,1'b1,2'b11}, // R3 counter kept
    {1'b1,1'b0,8'h5C, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R3 still cg: write cg[0]
    {1'b0,1'b0,8'h7F, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R4
    {1'b1,1'b1,8'h00, 1'b1,8'h99, 1'b1,1'b1,2'b11}, // R8 cg read 63
    {1'b1,1'b1,8'h00, 1'b1,8'h5C, 1'b1,1'b1,2'b11}, // R9 cg read wraps to 0
    {1'b0,1'b0,8'h85, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R5
    {1'b1,1'b1,8'h00, 1'b1,8'h41, 1'b1,1'b1,2'b11}, // R4 dd not aliased by cg
    {1'b0,1'b0,8'hFF, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R5 dd addr 127
    {1'b0,1'b1,8'h00, 1'b1,8'h7F, 1'b1,1'b1,2'b11}, // R6 counter 127, busy 0
    {1'b1,1'b0,8'h5A, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R7 write at 127
    {1'b0,1'b1,8'h00, 1'b1,8'h00, 1'b1,1'b1,2'b11}, // R9 dd wrap to 0
    {1'b0,1'b0,8'hFF, 1'b0,8'h00, 1'b1,1'b1,2'b11}, // R5
    {1'b1,1'b1,8'h00, 1'b1,8'h5A, 1'b1,1'b1,2'b11}, // R8 read 127
    {1'b0,1'b0,8'h24, 1'b0,8'h00, 1'b0,1'b0,2'b00}, // R2 byte[2] set
    {1'b0,1'b0,8'h20, 1'b0,8'h00, 1'b0,1'b0,2'b00}  // R2 byte[2] clear, same result
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic r_s, input logic r_w, input logic [7:0] b);
    stb = 1'b1; rs = r_s; rw = r_w; din = b;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0;
  endtask

  initial begin
    #(4 * 50000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; stb = 1'b0; rs = 1'b0; rw = 1'b0; din = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 wide", {7'd0, wide}, 8'd1);
    chk("R1 two", {7'd0, two}, 8'd1);
    chk("R1 bright", {6'd0, bright}, 8'd0);
    chk("R1 valid", {7'd0, rd_valid}, 8'd0);

    // vector table, one access per clock with no gap (R10)
    for (int i = 0; i < NV; i++) begin
      stb = 1'b1;
      rs  = VEC[i][22];
      rw  = VEC[i][21];
      din = VEC[i][20:13];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 v%0d valid", i), {7'd0, rd_valid}, {7'd0, VEC[i][12]});
      if (VEC[i][12])
        chk($sformatf("R8 v%0d data", i), rd_data, VEC[i][11:4]);
      chk($sformatf("R2 v%0d cfg", i), {4'd0, wide, two, bright}, {4'd0, VEC[i][3:0]});
    end
    stb = 1'b0;

    // R1: reset mid-run restores defaults and the display-data selection
    access(1'b0, 1'b0, 8'h7F);   // select cg
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 cfg after reset", {4'd0, wide, two, bright}, 8'b0000_1100);
    access(1'b0, 1'b1, 8'h00);
    chk("R1 counter after reset", rd_data, 8'h00);
    access(1'b1, 1'b0, 8'h77);   // must land in dd[0]
    access(1'b0, 1'b0, 8'h80);
    access(1'b1, 1'b1, 8'h00);
    chk("R1 dd selected after reset", rd_data, 8'h77);

    // R11: undecoded code with all low bits set changes nothing
    access(1'b0, 1'b0, 8'h1F);
    chk("R11 cfg unchanged", {4'd0, wide, two, bright}, 8'b0000_1100);
    access(1'b0, 1'b1, 8'h00);
    chk("R11 counter unchanged", rd_data, 8'h01);
    // R6: idle cycle after a read drops the valid pulse
    @(negedge clk);
    chk("R6 valid one clock", {7'd0, rd_valid}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule